// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a frequency-synthesizer loop is locked by watching the correction pulses of its charge pump. It runs on the crystal reference clock. Its inputs are the up and down pump outputs of the phase/frequency detector and a strobe that marks the end of each comparison period. It drives a single lock flag, which a host-side status register can read.

The flag drops quickly and rises slowly. A single pump pulse that is wider than the allowed number of crystal cycles clears the flag at once. The flag is set again only after a fixed number of consecutive comparison periods have closed with no wide pulse in them.

With a 4 MHz crystal and a strobe once every 64 crystal cycles, the defaults give the following timing. Loss of lock is flagged within one 16 µs period. Regained lock is flagged 128 to 144 µs after the pulses become narrow again.

Top module: `pll_lock_detect`

## Requirements
- R1: While reset is asserted and at the first clock after it is released, `lock_o` is 0. The internal clean-period count also starts at zero.
- R2: A pump pulse, taken as `pump_up_i | pump_dn_i`, that is high for a single crystal cycle has no effect on the flag or on the clean-period count. This holds even when that cycle is a strobe cycle.
- R3: When the pump pulse is high in two consecutive cycles (more than `MAX_WIDTH_CYC`=1), `lock_o` is 0 after the clock edge that ends the second high cycle.
- R4: A run in which up and down follow each other with no gap is measured as one pulse. Up for one cycle followed at once by down for one cycle is a wide pulse.
- R5: Each strobe (`ref_strobe_i`=1) closes a comparison period. The clean-period count advances by one per strobe only if that period contained no wide pulse. `lock_o` rises at the clock edge of the strobe that completes the eighth (`CLEAN_RUNS`) consecutive clean period, and never at any other time.
- R6: A wide pulse resets the clean-period count to zero. The strobe that closes the spoiled period does not count. Eight further clean strobes are therefore needed before the flag sets.
- R7: Once set, `lock_o` stays 1 through any number of further clean periods. The count saturates.
- R8: A wide pulse whose second high cycle falls in the strobe cycle spoils the period that this strobe closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pump_up_i | input | 1 | Charge-pump up pulse, synchronous to clk_i |
| pump_dn_i | input | 1 | Charge-pump down pulse, synchronous to clk_i |
| ref_strobe_i | input | 1 | One-cycle marker closing each comparison period |
| lock_o | output | 1 | Registered lock flag |

## Verification
The block holds three pieces of state: the width count, the spoiled-period mark and the clean-period count. Each is visible at the port only through the timing of `lock_o`.

A width count that is off by one shows up on the very next cycle, as a flag that falls on a one-cycle pulse or stays up after a two-cycle pulse. A spoiled-period mark that is lost or held over, or a clean-period count that is not reset, shows up only later. The flag then rises one strobe early or late, up to eight periods after the fault.

The bench therefore compares the flag against a behavioural model on every cycle. It also runs complete relock sequences after every kind of spoiling event.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  typedef enum logic {
    PERIOD_CLEAN   = 1'b0,
    PERIOD_SPOILED = 1'b1
  } period_e;
endpackage

// File: rtl/lkd_width_meter.sv
module lkd_width_meter #(
  parameter int MAX_WIDTH_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic too_wide_o
);
  localparam int CW = (MAX_WIDTH_CYC < 2) ? 1 : $clog2(MAX_WIDTH_CYC + 1);

  generate
    if (MAX_WIDTH_CYC == 1) begin : g_single
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= pulse_i;
      end
      assign too_wide_o = pulse_i & prev_q;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      logic          at_max;
      assign at_max = (cnt_q == CW'(MAX_WIDTH_CYC));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (!pulse_i) cnt_q <= '0;
        else if (!at_max)  cnt_q <= cnt_q + 1'b1;
      end
      assign too_wide_o = pulse_i & at_max;
    end
  endgenerate
endmodule

// File: rtl/lkd_period_tracker.sv
module lkd_period_tracker
  import lkd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic too_wide_i,
  input  logic strobe_i,
  output logic clean_close_o
);
  period_e state_q;

  // A strobe cycle belongs to the period it closes.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         state_q <= PERIOD_CLEAN;
    else if (strobe_i)   state_q <= PERIOD_CLEAN;
    else if (too_wide_i) state_q <= PERIOD_SPOILED;
  end

  assign clean_close_o = strobe_i & (state_q == PERIOD_CLEAN) & ~too_wide_i;
endmodule

// File: rtl/lkd_run_counter.sv
module lkd_run_counter #(
  parameter int CLEAN_RUNS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clean_close_i,
  input  logic too_wide_i,
  output logic reached_o
);
  localparam int RW = $clog2(CLEAN_RUNS + 1);

  logic [RW-1:0] run_q;
  logic          full;

  assign full = (run_q == RW'(CLEAN_RUNS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    run_q <= '0;
    else if (too_wide_i)            run_q <= '0;
    else if (clean_close_i && !full) run_q <= run_q + 1'b1;
  end

  assign reached_o = clean_close_i & (run_q == RW'(CLEAN_RUNS - 1));
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int MAX_WIDTH_CYC = 1,
  parameter int CLEAN_RUNS    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pump_up_i,
  input  logic pump_dn_i,
  input  logic ref_strobe_i,
  output logic lock_o
);
  logic pulse;
  logic too_wide;
  logic clean_close;
  logic reached;
  logic lock_q;

  assign pulse = pump_up_i | pump_dn_i;

  lkd_width_meter #(.MAX_WIDTH_CYC(MAX_WIDTH_CYC)) u_width (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pulse_i    (pulse),
    .too_wide_o (too_wide)
  );

  lkd_period_tracker u_period (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .too_wide_i    (too_wide),
    .strobe_i      (ref_strobe_i),
    .clean_close_o (clean_close)
  );

  lkd_run_counter #(.CLEAN_RUNS(CLEAN_RUNS)) u_run (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clean_close_i (clean_close),
    .too_wide_i    (too_wide),
    .reached_o     (reached)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lock_q <= 1'b0;
    else if (too_wide) lock_q <= 1'b0;
    else if (reached)  lock_q <= 1'b1;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pump_up_i,
  input logic pump_dn_i,
  input logic ref_strobe_i,
  input logic lock_o
);
  logic pulse;
  assign pulse = pump_up_i | pump_dn_i;

  AST_WIDE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse && $past(pulse)) |=> !lock_o); // R3

  AST_HOLD_NO_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !(pulse && $past(pulse))) |=> lock_o); // R7

  AST_RISE_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(ref_strobe_i)); // R5

  AST_FALL_NEEDS_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> ($past(pulse, 1) && $past(pulse, 2))); // R3

  AST_RISE_NOT_AFTER_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> !($past(pulse, 1) && $past(pulse, 2))); // R8
endmodule

bind pll_lock_detect pll_lock_detect_chk u_chk (.*);

// File: tb/pll_lock_detect_tb.sv
module pll_lock_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0, dn = 1'b0, stb = 1'b0;
  logic lock;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  // behavioural reference state
  int  m_len = 0;
  bit  m_bad = 0;
  int  m_run = 0;
  bit  m_lock = 0;

  always #5 clk = ~clk;

  pll_lock_detect u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pump_up_i    (up),
    .pump_dn_i    (dn),
    .ref_strobe_i (stb),
    .lock_o       (lock)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_len = 0; m_bad = 0; m_run = 0; m_lock = 0;
    end else begin
      bit p, wide;
      p = up | dn;
      m_len = p ? m_len + 1 : 0;
      wide = p && (m_len >= 2);
      if (wide) begin
        m_run = 0;
        m_lock = 0;
      end
      if (stb) begin
        if (!m_bad && !wide) begin
          if (m_run < 8) m_run = m_run + 1;
          if (m_run == 8) m_lock = 1;
        end
        m_bad = 0;
      end else if (wide) begin
        m_bad = 1;
      end
    end
  end

  task automatic step(input bit u, input bit d, input bit s);
    @(negedge clk);
    if (rst_n) begin
      n_chk++;
      if (lock !== m_lock) begin
        n_fail++;
        $display("FAIL %s: lock_o=%0b expected %0b at %0t", cur_req, lock, m_lock, $time);
      end
    end
    up = u; dn = d; stb = s;
  endtask

  task automatic expect_lock(input bit e, input string tag);
    step(0, 0, 0);
    n_chk++;
    if (lock !== e) begin
      n_fail++;
      $display("FAIL %s: lock_o=%0b expected %0b at %0t", tag, lock, e, $time);
    end
  endtask

  task automatic quiet_period();
    for (int i = 0; i < 7; i++) step(0, 0, 0);
    step(0, 0, 1);
  endtask

  task automatic quiet_periods(input int n);
    for (int i = 0; i < n; i++) quiet_period();
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (lock !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: lock_o=%0b expected 0 in reset", lock);
    end
    rst_n = 1'b1;
    expect_lock(0, "R1");

    cur_req = "R5";
    quiet_periods(7);
    expect_lock(0, "R5");
    quiet_period();
    expect_lock(1, "R5");

    cur_req = "R2";
    step(1, 0, 0); step(0, 0, 0);
    step(0, 1, 0); step(0, 0, 0);
    step(1, 1, 0); step(0, 0, 0);
    step(0, 1, 1);
    expect_lock(1, "R2");

    cur_req = "R7";
    quiet_periods(3);
    expect_lock(1, "R7");

    cur_req = "R3";
    step(1, 0, 0); step(1, 0, 0);
    expect_lock(0, "R3");

    cur_req = "R6";
    step(0, 0, 1);
    quiet_periods(7);
    expect_lock(0, "R6");
    quiet_period();
    expect_lock(1, "R6");

    cur_req = "R4";
    step(1, 0, 0); step(0, 1, 0);
    expect_lock(0, "R4");
    step(0, 0, 1);
    quiet_periods(8);
    expect_lock(1, "R4");

    cur_req = "R6";
    quiet_periods(2);
    step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
    expect_lock(0, "R6");
    step(0, 0, 1);
    quiet_periods(5);
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 1);
    quiet_periods(1);
    expect_lock(0, "R6");
    quiet_periods(2);
    expect_lock(1, "R6");

    cur_req = "R8";
    for (int i = 0; i < 6; i++) step(0, 0, 0);
    step(1, 0, 0); step(1, 0, 1);
    expect_lock(0, "R8");
    quiet_periods(7);
    expect_lock(0, "R8");
    cur_req = "R2";
    for (int i = 0; i < 7; i++) step(0, 0, 0);
    step(0, 1, 1);
    expect_lock(1, "R2");

    step(0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule